// File: doc/BRIEF.md
# Multi-Line SPI Read Sequencer

This block is the controller-side engine for a single memory-read transaction on a SPI bus that can use one, two or four data lines. A one-cycle start pulse launches a transaction. The block then drives chip select and the serial clock through a fixed sequence of phases: an instruction, an address, an optional mode field, a number of idle wait clocks, and finally data reception. It returns the received word together with a one-cycle valid strobe.

The host supplies every setting on input pins. These are the line count, the transfer type, the instruction and address lengths, the mode enable and value, the wait count and the frame size. A phase whose length works out to zero is skipped. All settings and payload values are captured at the start pulse, so the host may change them freely while a transaction runs.

The serial clock runs at half the system clock. Each serial clock period is one low system cycle followed by one high system cycle. The serial clock idles low. Outgoing bits change while the clock is low. Incoming bits are captured on the system edge that ends the high half.

Top module: `wideReadSeq`

## Requirements
- R1: A start pulse is ignored, and chip select stays high, when the line-count code `frameFmt` is 00 or 11, or when the transfer type `xferType` is 11. Code 01 selects two lines and code 10 selects four lines.
- R2: A start pulse that arrives while `busy` is high is ignored. No second transaction follows the current one.
- R3: `instLenCode` sets the instruction length: 00 means no instruction phase, 01 means 4 bits, 10 means 8 bits and 11 means 16 bits. The instruction is taken from the low bits of `instVal` and sent most significant bit first.
- R4: The address length is 4 × `addrLenCode` bits, so 0 skips the phase and 15 gives 60 bits. The address is taken from the low bits of `addrVal` and sent most significant bit first.
- R5: With `xferType` 00, both instruction and address use one line. With 01, the instruction uses one line and the address uses the wide format. With 10, both use the wide format.
- R6: On one line, bits leave on ioOut[0] with ioOe = 0001. On two lines, ioOut[1:0] carry 2 bits per clock with ioOe = 0011, upper bit first. On four lines, ioOut[3:0] carry 4 bits per clock with ioOe = 1111. ioOe is 0000 whenever chip select is high.
- R7: When `modeEn` is high, the 8-bit `modeVal` is sent in the wide format immediately after the address. When `modeEn` is low, no mode phase occurs.
- R8: Exactly `waitCount` (0 to 31) serial clocks, with ioOe = 0000, separate the last control bit from the first data clock.
- R9: Data arrives in the wide format, most significant bit first, for (`frameCode`+1)×4 bits. When the last bit is in, `rxData` holds the bits right-justified with upper bits zero, and `rxValid` is high for exactly one cycle.
- R10: Chip select falls at least one system cycle before the first serial clock rise. It rises only after the last data clock, one cycle after `rxValid`. The serial clock is low while chip select is high.
- R11: `busy` rises in the cycle after an accepted start pulse and is high exactly while chip select is low.
- R12: Changes to any configuration or payload input after the start pulse do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch request |
| frameFmt | input | 2 | Wide line count: 01 two lines, 10 four lines |
| xferType | input | 2 | Line usage of instruction and address |
| instLenCode | input | 2 | Instruction length code |
| addrLenCode | input | 4 | Address length in 4-bit units |
| modeEn | input | 1 | Enables the mode field |
| modeVal | input | 8 | Mode field value |
| waitCount | input | 5 | Idle serial clocks before data |
| frameCode | input | 3 | Received frame size code, bits = (code+1)×4 |
| instVal | input | 16 | Instruction value, right-justified |
| addrVal | input | 60 | Address value, right-justified |
| ioIn | input | 4 | Data lines sampled from the bus |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| ioOut | output | 4 | Data lines driven to the bus |
| ioOe | output | 4 | Per-line output enable |
| rxData | output | 32 | Received word |
| rxValid | output | 1 | One-cycle strobe for rxData |
| busy | output | 1 | Transaction in progress |

## Verification
The assertions assume that `start` is a clean synchronous level, sampled only at clock edges, and that reset is applied before the first start pulse. They place no demands on the configuration pins beyond that, because reserved codes are themselves checked to be harmless. The stimulus draws line count, transfer type, lengths, wait count and frame size only from their legal ranges for accepted transactions. Reserved codes and starts during a busy transaction are applied only in dedicated directed cases. The slave model drives `ioIn` while the serial clock is high, so each bit is stable before the edge that captures it.

// File: rtl/wideReadPkg.sv
package wideReadPkg;

  localparam int SR_W  = 64;
  localparam int CNT_W = 7;

  typedef logic [CNT_W-1:0] cnt_t;
  // lane selector doubles as the shift amount: 0 -> 1 line, 1 -> 2, 2 -> 4
  typedef logic [1:0] lanes_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_INST = 3'd1,
    PH_ADDR = 3'd2,
    PH_MODE = 3'd3,
    PH_WAIT = 3'd4,
    PH_DATA = 3'd5,
    PH_DONE = 3'd6
  } phase_e;

  typedef struct packed {
    cnt_t   instCyc;
    cnt_t   addrCyc;
    cnt_t   modeCyc;
    cnt_t   waitCyc;
    cnt_t   dataCyc;
    cnt_t   instBits;
    cnt_t   addrBits;
    lanes_t instLanes;
    lanes_t addrLanes;
    lanes_t wideLanes;
  } cfg_t;

  typedef struct packed {
    logic   capture;
    logic   load;
    phase_e loadPhase;
    cnt_t   loadBits;
    logic   shiftOut;
    logic   sampleIn;
    logic   finish;
    lanes_t lanes;
    logic   driveEn;
  } strobe_t;

endpackage

// File: rtl/wideReadCtrl.sv
module wideReadCtrl
  import wideReadPkg::*;
#(
  parameter int MODE_W = 8,
  parameter int FC_W   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      frameFmt,
  input  logic [1:0]      xferType,
  input  logic [1:0]      instLenCode,
  input  logic [3:0]      addrLenCode,
  input  logic            modeEn,
  input  logic [4:0]      waitCount,
  input  logic [FC_W-1:0] frameCode,
  output strobe_t         strb,
  output logic            sclk,
  output logic            csN,
  output logic            busy
);

  phase_e phase;
  phase_e nxt;
  cnt_t   cnt;
  logic   half;
  cfg_t   held;
  cfg_t   live;
  cfg_t   useCfg;
  lanes_t wideLn;
  cnt_t   dataBits;
  logic   fmtOk;
  logic   launch;
  logic   active;
  logic   ctrlPhase;
  logic   endOfCyc;
  logic   lastCyc;

  function automatic phase_e pickNext(phase_e cur, cfg_t c);
    if (cur < PH_INST && c.instCyc != '0) return PH_INST;
    if (cur < PH_ADDR && c.addrCyc != '0) return PH_ADDR;
    if (cur < PH_MODE && c.modeCyc != '0) return PH_MODE;
    if (cur < PH_WAIT && c.waitCyc != '0) return PH_WAIT;
    return PH_DATA;
  endfunction

  function automatic cnt_t cycOf(phase_e p, cfg_t c);
    case (p)
      PH_INST: return c.instCyc;
      PH_ADDR: return c.addrCyc;
      PH_MODE: return c.modeCyc;
      PH_WAIT: return c.waitCyc;
      default: return c.dataCyc;
    endcase
  endfunction

  // settings decoded from the pins, captured into held at launch
  always_comb begin
    wideLn         = (frameFmt == 2'b10) ? 2'd2 : 2'd1;
    live.wideLanes = wideLn;
    live.instLanes = (xferType == 2'b10) ? wideLn : 2'd0;
    live.addrLanes = (xferType == 2'b00) ? 2'd0 : wideLn;
    case (instLenCode)
      2'd0:    live.instBits = cnt_t'(0);
      2'd1:    live.instBits = cnt_t'(4);
      2'd2:    live.instBits = cnt_t'(8);
      default: live.instBits = cnt_t'(16);
    endcase
    live.addrBits = cnt_t'({addrLenCode, 2'b00});
    live.instCyc  = live.instBits >> live.instLanes;
    live.addrCyc  = live.addrBits >> live.addrLanes;
    live.modeCyc  = modeEn ? (cnt_t'(MODE_W) >> wideLn) : '0;
    live.waitCyc  = cnt_t'(waitCount);
    dataBits      = cnt_t'({frameCode, 2'b00}) + cnt_t'(4);
    live.dataCyc  = dataBits >> wideLn;
  end

  assign fmtOk     = (frameFmt == 2'b01 || frameFmt == 2'b10) && (xferType != 2'b11);
  assign launch    = (phase == PH_IDLE) && start && fmtOk;
  assign active    = (phase != PH_IDLE) && (phase != PH_DONE);
  assign ctrlPhase = (phase == PH_INST) || (phase == PH_ADDR) || (phase == PH_MODE);
  assign endOfCyc  = active && half;
  assign lastCyc   = (cnt == cnt_t'(1));
  assign useCfg    = (phase == PH_IDLE) ? live : held;
  assign nxt       = pickNext(phase, useCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      half  <= 1'b0;
      held  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          half <= 1'b0;
          if (launch) begin
            phase <= nxt;
            cnt   <= cycOf(nxt, live);
            held  <= live;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: begin
          half <= ~half;
          if (half) begin
            if (lastCyc) begin
              if (phase == PH_DATA) phase <= PH_DONE;
              else begin
                phase <= nxt;
                cnt   <= cycOf(nxt, held);
              end
            end else begin
              cnt <= cnt - cnt_t'(1);
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.capture   = launch;
    strb.load      = launch || (endOfCyc && lastCyc && phase != PH_DATA);
    strb.loadPhase = nxt;
    case (nxt)
      PH_INST: strb.loadBits = useCfg.instBits;
      PH_ADDR: strb.loadBits = useCfg.addrBits;
      PH_MODE: strb.loadBits = cnt_t'(MODE_W);
      default: strb.loadBits = '0;
    endcase
    strb.shiftOut = endOfCyc && !lastCyc && ctrlPhase;
    strb.sampleIn = endOfCyc && (phase == PH_DATA);
    strb.finish   = endOfCyc && lastCyc && (phase == PH_DATA);
    case (phase)
      PH_INST: strb.lanes = held.instLanes;
      PH_ADDR: strb.lanes = held.addrLanes;
      default: strb.lanes = held.wideLanes;
    endcase
    strb.driveEn = ctrlPhase;
  end

  assign sclk = active && half;
  assign csN  = (phase == PH_IDLE);
  assign busy = (phase != PH_IDLE);

  // R1: a start with a reserved code leaves the block idle
  a_r1_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !fmtOk) |=> !busy);

  // R2: a start during a running transaction does not disturb it
  a_r2_busy_start_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && phase != PH_DONE) |=> busy);

  // R11: busy only rises after a start request
  a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/wideReadDp.sv
module wideReadDp
  import wideReadPkg::*;
#(
  parameter int MODE_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [15:0]       instVal,
  input  logic [59:0]       addrVal,
  input  logic [MODE_W-1:0] modeVal,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  logic [15:0]       hInst;
  logic [59:0]       hAddr;
  logic [MODE_W-1:0] hMode;
  logic [SR_W-1:0]   sr;
  logic [SR_W-1:0]   loadVal;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  always_comb begin
    case (strb.loadPhase)
      PH_INST: loadVal = SR_W'(strb.capture ? instVal : hInst);
      PH_ADDR: loadVal = SR_W'(strb.capture ? addrVal : hAddr);
      PH_MODE: loadVal = SR_W'(strb.capture ? modeVal : hMode);
      default: loadVal = '0;
    endcase
  end

  always_comb begin
    case (strb.lanes)
      2'd1:    rxNext = {rxShift[DATA_W-3:0], ioIn[1:0]};
      2'd2:    rxNext = {rxShift[DATA_W-5:0], ioIn};
      default: rxNext = {rxShift[DATA_W-2:0], ioIn[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hInst   <= '0;
      hAddr   <= '0;
      hMode   <= '0;
      sr      <= '0;
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strb.capture) begin
        hInst <= instVal;
        hAddr <= addrVal;
        hMode <= modeVal;
      end
      if (strb.load) begin
        sr <= loadVal << (cnt_t'(SR_W) - strb.loadBits);
      end else if (strb.shiftOut) begin
        case (strb.lanes)
          2'd0:    sr <= sr << 1;
          2'd1:    sr <= sr << 2;
          default: sr <= sr << 4;
        endcase
      end
      if (strb.load && strb.loadPhase == PH_DATA) rxShift <= '0;
      else if (strb.sampleIn) rxShift <= rxNext;
      rxValid <= strb.finish;
      if (strb.finish) rxData <= rxNext;
    end
  end

  always_comb begin
    case (strb.lanes)
      2'd0:    begin ioOut = {3'b000, sr[SR_W-1]};   ioOe = 4'b0001; end
      2'd1:    begin ioOut = {2'b00, sr[SR_W-1 -: 2]}; ioOe = 4'b0011; end
      default: begin ioOut = sr[SR_W-1 -: 4];        ioOe = 4'b1111; end
    endcase
    if (!strb.driveEn) ioOe = 4'b0000;
  end

  // R9: the received word is announced for one cycle only
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/wideReadSeq.sv
module wideReadSeq
  import wideReadPkg::*;
#(
  parameter  int MODE_W = 8,
  parameter  int DATA_W = 32,
  localparam int FC_W   = $clog2(DATA_W / 4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        frameFmt,
  input  logic [1:0]        xferType,
  input  logic [1:0]        instLenCode,
  input  logic [3:0]        addrLenCode,
  input  logic              modeEn,
  input  logic [MODE_W-1:0] modeVal,
  input  logic [4:0]        waitCount,
  input  logic [FC_W-1:0]   frameCode,
  input  logic [15:0]       instVal,
  input  logic [59:0]       addrVal,
  input  logic [3:0]        ioIn,
  output logic              sclk,
  output logic              csN,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              busy
);

  strobe_t strb;

  wideReadCtrl #(.MODE_W(MODE_W), .FC_W(FC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .frameFmt(frameFmt), .xferType(xferType), .instLenCode(instLenCode),
    .addrLenCode(addrLenCode), .modeEn(modeEn), .waitCount(waitCount),
    .frameCode(frameCode), .strb(strb), .sclk(sclk), .csN(csN), .busy(busy)
  );

  wideReadDp #(.MODE_W(MODE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .instVal(instVal), .addrVal(addrVal), .modeVal(modeVal), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .rxData(rxData), .rxValid(rxValid)
  );

  // R10: chip select releases only right after the word is delivered
  a_r10_cs_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $past(rxValid));

  // R6: lines are never driven while deselected
  a_r6_oe_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (ioOe == 4'b0000));

endmodule

// File: tb/wideReadSeq_tb.sv
module wideReadSeq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  frameFmt = 2'b01;
  logic [1:0]  xferType = 2'b00;
  logic [1:0]  instLenCode = 2'b00;
  logic [3:0]  addrLenCode = 4'd0;
  logic        modeEn = 1'b0;
  logic [7:0]  modeVal = 8'h00;
  logic [4:0]  waitCount = 5'd0;
  logic [2:0]  frameCode = 3'd0;
  logic [15:0] instVal = 16'h0;
  logic [59:0] addrVal = 60'h0;
  logic [3:0]  ioIn = 4'h0;
  logic        sclk, csN, rxValid, busy;
  logic [3:0]  ioOut, ioOe;
  logic [31:0] rxData;

  wideReadSeq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .frameFmt(frameFmt),
    .xferType(xferType), .instLenCode(instLenCode), .addrLenCode(addrLenCode),
    .modeEn(modeEn), .modeVal(modeVal), .waitCount(waitCount),
    .frameCode(frameCode), .instVal(instVal), .addrVal(addrVal), .ioIn(ioIn),
    .sclk(sclk), .csN(csN), .ioOut(ioOut), .ioOe(ioOe), .rxData(rxData),
    .rxValid(rxValid), .busy(busy)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // expected transaction shape
  int tInstBits, tInstN, tAddrBits, tAddrN, tModeBits, tWideN, tWait, tDataBits;
  int nI, nA, nM, nW, nD;
  logic [63:0] tInst, tAddr, tMode, tData;

  // monitor results
  int edgeCnt, mmI, mmA, mmM, mmW, rxCount, csBad, busyBad;
  logic [31:0] rxGot;
  logic prevSclk = 1'b0;
  logic prevCsN = 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] laneMask(int n);
    return (n == 1) ? 4'h1 : (n == 2) ? 4'h3 : 4'hF;
  endfunction

  function automatic logic [3:0] pick(logic [63:0] v, int bits, int n, int j);
    logic [63:0] t;
    t = v >> (bits - n * (j + 1));
    return t[3:0] & laneMask(n);
  endfunction

  // bus slave and observer, away from the active edge
  always @(negedge clk) begin
    if (csN && sclk) csBad++;
    if (busy == csN) busyBad++;
    if (rxValid) begin
      rxCount++;
      rxGot = rxData;
    end
    if (sclk && !prevSclk) begin
      if (edgeCnt == 0 && prevCsN) csBad++;
      if (edgeCnt < nI) begin
        if (ioOe != laneMask(tInstN) || (ioOut & ioOe) != pick(tInst, tInstBits, tInstN, edgeCnt)) mmI++;
      end else if (edgeCnt < nI + nA) begin
        if (ioOe != laneMask(tAddrN) || (ioOut & ioOe) != pick(tAddr, tAddrBits, tAddrN, edgeCnt - nI)) mmA++;
      end else if (edgeCnt < nI + nA + nM) begin
        if (ioOe != laneMask(tWideN) || (ioOut & ioOe) != pick(tMode, tModeBits, tWideN, edgeCnt - nI - nA)) mmM++;
      end else begin
        if (ioOe != 4'h0) mmW++;
        if (edgeCnt >= nI + nA + nM + nW)
          ioIn = pick(tData, tDataBits, tWideN, edgeCnt - (nI + nA + nM + nW));
      end
      edgeCnt++;
    end
    prevSclk = sclk;
    prevCsN  = csN;
  end

  task automatic runTxn(input logic [1:0] f, input logic [1:0] tt, input logic [1:0] ic,
                        input logic [3:0] ac, input logic me, input logic [4:0] w,
                        input logic [2:0] fc, input bit scramble, input bit restart);
    int guard;
    int relaunch;
    logic [31:0] expRx;
    tWideN    = (f == 2'b10) ? 4 : 2;
    tInstBits = (ic == 0) ? 0 : (ic == 1) ? 4 : (ic == 2) ? 8 : 16;
    tInstN    = (tt == 2'b10) ? tWideN : 1;
    tAddrN    = (tt == 2'b00) ? 1 : tWideN;
    tAddrBits = 4 * int'(ac);
    tModeBits = me ? 8 : 0;
    tWait     = int'(w);
    tDataBits = (int'(fc) + 1) * 4;
    tInst = {$urandom, $urandom};
    tAddr = {$urandom, $urandom};
    tMode = {$urandom, $urandom};
    tData = {$urandom, $urandom};
    expRx = 32'(tData & ((64'd1 << tDataBits) - 64'd1));
    nI = tInstBits / tInstN;
    nA = tAddrBits / tAddrN;
    nM = tModeBits / tWideN;
    nW = tWait;
    nD = tDataBits / tWideN;
    edgeCnt = 0; mmI = 0; mmA = 0; mmM = 0; mmW = 0;
    rxCount = 0; csBad = 0; busyBad = 0; rxGot = '0; relaunch = 0;
    @(negedge clk);
    frameFmt = f; xferType = tt; instLenCode = ic; addrLenCode = ac;
    modeEn = me; waitCount = w; frameCode = fc;
    instVal = tInst[15:0]; addrVal = tAddr[59:0]; modeVal = tMode[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", longint'(busy), 1);
    if (scramble) begin
      frameFmt = ~f; xferType = 2'(tt + 1); instLenCode = ~ic; addrLenCode = ~ac;
      modeEn = ~me; waitCount = ~w; frameCode = ~fc;
      instVal = ~instVal; addrVal = ~addrVal; modeVal = ~modeVal;
    end
    if (restart) begin
      repeat (3) @(negedge clk);
      if (busy) begin
        frameFmt = 2'b10; xferType = 2'b10; instLenCode = 2'b11; waitCount = 5'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    guard = 0;
    while (busy && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) begin
      @(negedge clk);
      if (!csN) relaunch++;
    end
    chk(edgeCnt == nI + nA + nM + nW + nD, "R8 total serial clocks", edgeCnt, nI + nA + nM + nW + nD);
    chk(mmI == 0, "R3,R5,R6 instruction bits", mmI, 0);
    chk(mmA == 0, "R4,R5,R6 address bits", mmA, 0);
    chk(mmM == 0, "R7 mode bits", mmM, 0);
    chk(mmW == 0, "R8 lines released in wait/data", mmW, 0);
    chk(rxCount == 1, "R9 one valid pulse", rxCount, 1);
    chk(rxGot == expRx, "R9 received word", rxGot, expRx);
    chk(csBad == 0, "R10 chip select ordering", csBad, 0);
    chk(busyBad == 0, "R11 busy tracks chip select", busyBad, 0);
    chk(relaunch == 0, "R2 no extra transaction", relaunch, 0);
    if (scramble)
      chk(mmI + mmA + mmM + mmW == 0 && rxGot == expRx, "R12 inputs held at start",
          mmI + mmA + mmM + mmW, 0);
  endtask

  task automatic badStart(input logic [1:0] f, input logic [1:0] tt);
    int seen;
    seen = 0;
    @(negedge clk);
    frameFmt = f; xferType = tt; instLenCode = 2'b10; addrLenCode = 4'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      if (busy || !csN || sclk || ioOe != 4'h0) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R1 reserved code ignored", seen, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    nI = 0; nA = 0; nM = 0; nW = 0; nD = 0;
    tInstN = 1; tAddrN = 1; tWideN = 2;
    tInstBits = 0; tAddrBits = 0; tModeBits = 0; tDataBits = 4;
    tInst = '0; tAddr = '0; tMode = '0; tData = '0;
    edgeCnt = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0, "R10 idle after reset", {csN, sclk}, 2'b10);
    chk(ioOe == 4'h0 && !busy && !rxValid, "R11 quiet after reset", {ioOe, busy, rxValid}, 0);

    runTxn(2'b10, 2'b10, 2'd3, 4'd15, 1'b1, 5'd31, 3'd7, 1'b0, 1'b0);
    runTxn(2'b01, 2'b00, 2'd0, 4'd0,  1'b0, 5'd0,  3'd0, 1'b0, 1'b0);
    runTxn(2'b01, 2'b00, 2'd3, 4'd15, 1'b1, 5'd0,  3'd7, 1'b0, 1'b0);
    runTxn(2'b10, 2'b01, 2'd1, 4'd1,  1'b0, 5'd1,  3'd0, 1'b0, 1'b0);
    runTxn(2'b01, 2'b10, 2'd2, 4'd6,  1'b1, 5'd8,  3'd3, 1'b0, 1'b1);
    runTxn(2'b10, 2'b01, 2'd2, 4'd8,  1'b1, 5'd4,  3'd5, 1'b1, 1'b0);
    badStart(2'b00, 2'b00);
    badStart(2'b11, 2'b10);
    badStart(2'b01, 2'b11);
    for (int i = 0; i < 40; i++) begin
      runTxn(2'($urandom_range(1, 2)), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)),
             4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
             3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule